// File: doc/BRIEF.md
# Program Counter with Return Stack

This block keeps the fetch address of a small microcontroller core and a return-address store for subroutine calls and interrupts. Once per instruction cycle it either steps to the next address or loads a new one. A new address can come from a write of the low address byte, which takes its upper bits from a 5-bit page latch. It can come from a jump or call, which takes an 11-bit target field from the opcode and its two top bits from the latch. It can also be the interrupt entry address, or a return address taken off the stack.

The stack has eight 13-bit entries in a ring. Pushing a ninth value overwrites the oldest entry, and nothing reports that it happened. The pointer is hidden from software. The instruction decoder raises `push` for a call or interrupt entry and `pop` for any kind of return. The page latch is an input that the block only reads. The fetch address wraps inside the implemented program size, which is a parameter (2K words by default).

Top module: `pc_retstack`

## Requirements
- R1: While `rst` is high at a rising edge, the fetch address becomes 0000h, the reset entry address.
- R2: In a cycle with `cyc_en` high and no load request, the fetch address becomes the old address plus one. In a cycle with `cyc_en` low, the address, the stack and the stack pointer all hold.
- R3: An enabled cycle with `lo_wr` high loads `lo_data` into address bits 7:0 and `page_latch[4:0]` into address bits 12:8.
- R4: An enabled cycle with `jmp` high loads `jmp_tgt[10:0]` into address bits 10:0 and `page_latch[4:3]` into address bits 12:11.
- R5: An enabled cycle with `vec` high loads the interrupt entry address 0004h.
- R6: An enabled `push` stores the address after the current one (old fetch address plus one, wrapped). The store uses the value from before any load made in the same cycle. An enabled `pop` loads the most recently pushed value that has not yet been popped.
- R7: The stack is an 8-entry ring. After ten pushes A1..A10, ten pops return A10, A9, ..., A3, then A10 and A9 again.
- R8: The fetch address always wraps modulo PROG_WORDS. Address bits at or above log2(PROG_WORDS) are zero, and stepping from PROG_WORDS-1 gives 0.
- R9: When several load requests arrive in one cycle, the priority is `lo_wr`, then `jmp`, then `vec`, then `pop`. A pop that loses still moves the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle strobe; nothing changes while low |
| lo_wr | input | 1 | Write of the address low byte |
| lo_data | input | 8 | Low-byte value from the ALU |
| page_latch | input | 5 | Upper-address latch register |
| jmp | input | 1 | Jump or call target load |
| jmp_tgt | input | 11 | Target field of the opcode |
| vec | input | 1 | Interrupt entry |
| push | input | 1 | Push return address (call, interrupt entry) |
| pop | input | 1 | Pop return address (any return) |
| fetch_addr | output | 13 | Registered fetch address |

## Verification
Every result is due one clock after the cycle that requests it. `fetch_addr` is the register itself, so a step, any load or a pop shows up right after the rising edge that samples the request. A pushed value is only seen when a later pop brings it back, one edge after that pop. The bench drives each request just after an edge and compares its own model shortly after the following edge. It sweeps every page-latch value, runs the address through the wrap point, and fills the ring past its depth.

// File: rtl/pcrs_pkg.sv
package pcrs_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LOW  = 3'd2,
    SRC_JMP  = 3'd3,
    SRC_VEC  = 3'd4,
    SRC_RET  = 3'd5
  } pc_src_e;
endpackage

// File: rtl/pcrs_src_sel.sv
module pcrs_src_sel
  import pcrs_pkg::*;
(
  input  logic    cyc_en,
  input  logic    lo_wr,
  input  logic    jmp,
  input  logic    vec,
  input  logic    pop,
  output pc_src_e src
);
  // fixed priority: low-byte write, jump, vector, return, step
  always_comb begin
    if (!cyc_en)    src = SRC_HOLD;
    else if (lo_wr) src = SRC_LOW;
    else if (jmp)   src = SRC_JMP;
    else if (vec)   src = SRC_VEC;
    else if (pop)   src = SRC_RET;
    else            src = SRC_INC;
  end
endmodule

// File: rtl/pcrs_ring.sv
module pcrs_ring #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_m1;

  assign ptr_m1  = ptr_q - PW'(1);
  assign top_val = mem[ptr_m1];

  // entries carry no reset so the array can map to RAM
  always_ff @(posedge clk) begin
    if (push) mem[ptr_q] <= push_val;
  end

  // pointer wraps freely; no overflow or underflow tracking
  always_ff @(posedge clk) begin
    if (rst)                ptr_q <= '0;
    else if (push && !pop)  ptr_q <= ptr_q + PW'(1);
    else if (pop && !push)  ptr_q <= ptr_m1;
  end
endmodule

// File: rtl/pc_retstack.sv
module pc_retstack
  import pcrs_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int DATA_W     = 8,
  parameter int TGT_W      = 11,
  parameter int DEPTH      = 8,
  parameter int PROG_WORDS = 2048,
  parameter int INT_VEC    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cyc_en,
  input  logic                   lo_wr,
  input  logic [DATA_W-1:0]      lo_data,
  input  logic [PC_W-DATA_W-1:0] page_latch,
  input  logic                   jmp,
  input  logic [TGT_W-1:0]       jmp_tgt,
  input  logic                   vec,
  input  logic                   push,
  input  logic                   pop,
  output logic [PC_W-1:0]        fetch_addr
);
  localparam int LATCH_W = PC_W - DATA_W;
  localparam int JHI_W   = PC_W - TGT_W;
  localparam int AW      = $clog2(PROG_WORDS);

  pc_src_e         src;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_raw;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] ret_val;

  pcrs_src_sel u_sel (
    .cyc_en (cyc_en),
    .lo_wr  (lo_wr),
    .jmp    (jmp),
    .vec    (vec),
    .pop    (pop),
    .src    (src)
  );

  // the folded increment serves both the step and the pushed return address
  generate
    if (AW < PC_W) begin : g_fold
      assign pc_inc = {{(PC_W-AW){1'b0}}, pc_q[AW-1:0] + AW'(1)};
      assign pc_d   = {{(PC_W-AW){1'b0}}, pc_raw[AW-1:0]};
    end else begin : g_full
      assign pc_inc = pc_q + PC_W'(1);
      assign pc_d   = pc_raw;
    end
  endgenerate

  pcrs_ring #(.W(PC_W), .DEPTH(DEPTH)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .push     (push && cyc_en),
    .pop      (pop && cyc_en),
    .push_val (pc_inc),
    .top_val  (ret_val)
  );

  always_comb begin
    unique case (src)
      SRC_LOW: pc_raw = {page_latch, lo_data};
      SRC_JMP: pc_raw = {page_latch[LATCH_W-1 -: JHI_W], jmp_tgt};
      SRC_VEC: pc_raw = PC_W'(INT_VEC);
      SRC_RET: pc_raw = ret_val;
      SRC_INC: pc_raw = pc_inc;
      default: pc_raw = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
endmodule

// File: rtl/pc_retstack_chk.sv
module pc_retstack_chk #(
  parameter int PC_W       = 13,
  parameter int DATA_W     = 8,
  parameter int TGT_W      = 11,
  parameter int PROG_WORDS = 2048,
  parameter int INT_VEC    = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cyc_en,
  input logic                   lo_wr,
  input logic [DATA_W-1:0]      lo_data,
  input logic [PC_W-DATA_W-1:0] page_latch,
  input logic                   jmp,
  input logic [TGT_W-1:0]       jmp_tgt,
  input logic                   vec,
  input logic                   pop,
  input logic [PC_W-1:0]        fetch_addr
);
  localparam int LATCH_W = PC_W - DATA_W;
  localparam int JHI_W   = PC_W - TGT_W;
  localparam logic [PC_W-1:0] LIM = PC_W'(PROG_WORDS - 1);

  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> fetch_addr == '0);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> fetch_addr == $past(fetch_addr));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && !lo_wr && !jmp && !vec && !pop)
    |=> fetch_addr == (LIM & PC_W'($past(fetch_addr) + PC_W'(1))));

  a_r3_low_byte: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && lo_wr)
    |=> fetch_addr == (LIM & {$past(page_latch), $past(lo_data)}));

  a_r4_jump: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && !lo_wr && jmp)
    |=> fetch_addr == (LIM & {$past(page_latch[LATCH_W-1 -: JHI_W]), $past(jmp_tgt)}));

  a_r5_vector: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && !lo_wr && !jmp && vec)
    |=> fetch_addr == (LIM & PC_W'(INT_VEC)));

  a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
    cyc_en |=> fetch_addr <= LIM);
endmodule

bind pc_retstack pc_retstack_chk #(
  .PC_W(PC_W), .DATA_W(DATA_W), .TGT_W(TGT_W),
  .PROG_WORDS(PROG_WORDS), .INT_VEC(INT_VEC)
) u_chk (
  .clk(clk), .rst(rst), .cyc_en(cyc_en), .lo_wr(lo_wr), .lo_data(lo_data),
  .page_latch(page_latch), .jmp(jmp), .jmp_tgt(jmp_tgt), .vec(vec),
  .pop(pop), .fetch_addr(fetch_addr)
);

// File: tb/pc_retstack_tb.sv
module pc_retstack_tb;
  localparam int MASK = 2047;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_en = 1'b0, lo_wr = 1'b0, jmp = 1'b0, vec = 1'b0, push = 1'b0, pop = 1'b0;
  logic [7:0]  lo_data = '0;
  logic [4:0]  page_latch = '0;
  logic [10:0] jmp_tgt = '0;
  logic [12:0] fetch_addr;

  int n_chk = 0, n_fail = 0;
  int exp_pc = 0;
  int ring [8];
  int sp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pc_retstack u_dut (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .lo_wr(lo_wr), .lo_data(lo_data),
    .page_latch(page_latch), .jmp(jmp), .jmp_tgt(jmp_tgt), .vec(vec),
    .push(push), .pop(pop), .fetch_addr(fetch_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: fetch_addr actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle, advance the model, compare just after the edge
  task automatic cyc(input string req, input bit en, input bit lw, input int ld,
                     input int lat, input bit jp, input int tg, input bit vc,
                     input bit ps, input bit pp);
    int nxt;
    int old_sp;
    cyc_en = en; lo_wr = lw; lo_data = 8'(ld); page_latch = 5'(lat);
    jmp = jp; jmp_tgt = 11'(tg); vec = vc; push = ps; pop = pp;
    nxt = exp_pc;
    old_sp = sp;
    if (en) begin
      if (lw)      nxt = (lat << 8) | (ld & 255);
      else if (jp) nxt = ((lat >> 3) << 11) | (tg & 2047);
      else if (vc) nxt = 4;
      else if (pp) nxt = ring[(old_sp + 7) % 8];
      else         nxt = exp_pc + 1;
      if (ps && !pp) begin
        ring[old_sp] = (exp_pc + 1) & MASK;
        sp = (old_sp + 1) % 8;
      end else if (pp && !ps) begin
        sp = (old_sp + 7) % 8;
      end
    end
    exp_pc = nxt & MASK;
    @(posedge clk); #1;
    check(req, int'(fetch_addr), exp_pc);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc_en = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    exp_pc = 0; sp = 0;
    check("R1", int'(fetch_addr), 0);
  endtask

  initial begin
    #1;
    do_reset();
    // R2/R8: step through the wrap point
    for (int i = 0; i < 2100; i++) cyc("R2_R8", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: idle cycles hold, even with requests present
    for (int i = 0; i < 5; i++) cyc("R2", 0, 1, 8'h3c, 7, 1, 5, 1, 1, 1);
    // R3/R8: every latch value with several data bytes
    for (int l = 0; l < 32; l++) begin
      cyc("R3", 1, 1, 8'h00, l, 0, 0, 0, 0, 0);
      cyc("R3", 1, 1, 8'ha5, l, 0, 0, 0, 0, 0);
      cyc("R3", 1, 1, 8'hff, l, 0, 0, 0, 0, 0);
      cyc("R2", 1, 0, 0, l, 0, 0, 0, 0, 0);
    end
    // R4/R8: every latch value with several targets
    for (int l = 0; l < 32; l++) begin
      cyc("R4", 1, 0, 0, l, 1, 11'h000, 0, 0, 0);
      cyc("R4", 1, 0, 0, l, 1, 11'h555, 0, 0, 0);
      cyc("R4", 1, 0, 0, l, 1, 11'h7ff, 0, 0, 0);
    end
    // R5/R6: interrupt entry with push, then return
    cyc("R4", 1, 0, 0, 0, 1, 11'h123, 0, 0, 0);
    cyc("R5", 1, 0, 0, 0, 0, 0, 1, 1, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    // R6: nested calls and returns, incl. call from the last word
    cyc("R4", 1, 0, 0, 0, 1, 11'h7ff, 0, 0, 0);
    cyc("R6", 1, 0, 0, 0, 1, 11'h200, 0, 1, 0);
    cyc("R6", 1, 0, 0, 24, 1, 11'h010, 0, 1, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R6", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    // R7: ten calls, then ten returns around the ring
    for (int k = 0; k < 10; k++) cyc("R7", 1, 0, 0, 0, 1, 11'h100 + 16 * k, 0, 1, 0);
    for (int k = 0; k < 10; k++) cyc("R7", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    // R9: priority among simultaneous loads
    cyc("R9", 1, 1, 8'h42, 3, 1, 11'h333, 1, 0, 1);
    cyc("R9", 1, 0, 0, 8, 1, 11'h0aa, 1, 0, 1);
    cyc("R9", 1, 0, 0, 0, 0, 0, 1, 0, 1);
    cyc("R9", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    // R1: reset in mid-run
    cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    do_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); n_chk++; n_fail++; $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule